// File: doc/BRIEF.md
# Serial Synthesizer Word Loader

This block loads a 32-bit programming word into up to three external frequency synthesizers over a three-wire serial link made of a data line, a clock line and per-synthesizer strobe lines. A host fills four byte-wide word registers and three byte-wide configuration registers through one byte port. The same port reads back every register and a status byte. A write to the last configuration register starts a transfer. The configuration sets how many clock pulses go out, the clock polarity, whether the word leaves least or most significant bit first, which strobe lines take part, and the bit times at which the strobe rises and falls.

The serial clock comes from dividing the system clock by the even parameter `CLK_DIV`. Each bit time lasts `CLK_DIV` system cycles. In the first half of a bit time the clock sits at its inactive level, and in the second half it sits at its active level. Data changes only at bit-time boundaries, so it is steady across the active edge. An out-of-lock input, which the board drives from the combined lock-fail signals of the synthesizers, gates the transmit path: the power-amplifier enable and both I/Q sample buses are held at zero while the input is high.

Top module: `synth_loader`

## Requirements
- R1: After reset, `ready` is 1, `sclk` is 0, `sdata` is 0, all strobes are 0 and every register reads 0, except configuration 2, which reads 0x20.
- R2: Addresses 0–3 hold word bytes 0 (least significant) to 3 (most significant). Address 4 holds select in bits 7:5 and the fall index in bits 4:0. Address 5 holds the order flag in bit 5 and the rise index in bits 4:0. Address 6 holds polarity in bit 5 and the pulse code in bits 4:0. Bits 7:6 of addresses 5 and 6 read 0. Address 7 reads status: bit 0 is ready, bit 1 is the out-of-lock level, and all other bits are 0.
- R3: A write to address 6 while `ready` is 1 drops `ready` from the next cycle on. `ready` stays low for exactly N·`CLK_DIV` cycles, where N is the pulse count.
- R4: A pulse code of 1–31 gives that many pulses, and code 0 gives 32.
- R5: With polarity 1, `sclk` is 0 in the first `CLK_DIV`/2 cycles of each bit time and 1 in the rest. With polarity 0, the clock is the inverse of that. When idle, `sclk` rests at the inactive level, which is 0 for polarity 1 and 1 for polarity 0.
- R6: With the order flag at 0, bit time k carries word bit k. With the flag at 1, bit time k carries word bit 31−k. `sdata` is 0 when idle.
- R7: `sdata` holds steady across the inactive-to-active clock edge inside a bit time.
- R8: The strobe level starts low at each transfer. It goes high at the start of the bit time equal to the rise index and low at the start of the bit time equal to the fall index. When both indices are equal, the fall wins. The strobe returns low when the transfer ends.
- R9: A rise or fall index equal to or above N never takes effect.
- R10: Strobe line i follows the strobe level only when select bit i (bit 5+i of address 4) is 1. Any combination of select bits may be set.
- R11: Writes to any register while `ready` is 0 are ignored, and the transfer in progress continues unchanged.
- R12: While `out_of_lock` is 1, `pa_en`, `txi` and `txq` are 0. Otherwise they equal `pa_en_in`, `txi_in` and `txq_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ready | output | 1 | 1 when idle, 0 while a transfer runs |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| strobe | output | 3 | Per-synthesizer latch strobes |
| out_of_lock | input | 1 | Combined lock-fail indication |
| pa_en_in | input | 1 | Requested power-amplifier enable |
| txi_in | input | IQ_W | Transmit I sample in |
| txq_in | input | IQ_W | Transmit Q sample in |
| pa_en | output | 1 | Gated power-amplifier enable |
| txi | output | IQ_W | Gated transmit I sample |
| txq | output | IQ_W | Gated transmit Q sample |

## Verification
The start write is registered at one rising edge, and the first bit time is visible right after that edge. The bench therefore samples each transfer on falling edges starting with the one that follows the write. Sample j belongs to bit time j/`CLK_DIV` and to clock phase j mod `CLK_DIV`. `ready` is expected back at sample N·`CLK_DIV`. Register reads and the lock gating are combinational, so the bench checks them shortly after it changes the inputs, in the same cycle. The expected bit, clock level and strobe level are all recomputed in the bench from the indices and the word. The strobe is recomputed with a closed-form rule rather than by stepping through a state.

// File: rtl/synl_pkg.sv
package synl_pkg;
  localparam int NSTB   = 3;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  localparam int CNT_W  = IDX_W + 1;

  localparam logic [2:0] A_CFG0 = 3'd4;
  localparam logic [2:0] A_CFG1 = 3'd5;
  localparam logic [2:0] A_CFG2 = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [NSTB-1:0]   sel;
    logic [IDX_W-1:0]  fall_idx;
    logic              msb_first;
    logic [IDX_W-1:0]  rise_idx;
    logic              pol;
    logic [IDX_W-1:0]  pcode;
  } synl_cfg_t;

  // code 0 stands for the full word
  function automatic logic [CNT_W-1:0] pulses_of(input logic [IDX_W-1:0] code);
    return (code == '0) ? CNT_W'(WORD_W) : {1'b0, code};
  endfunction

  function automatic logic bit_at(input logic [WORD_W-1:0] w,
                                  input logic msb,
                                  input logic [IDX_W-1:0] k);
    return msb ? w[WORD_W-1-int'(k)] : w[k];
  endfunction

  // strobe level entering bit time b
  function automatic logic strobe_step(input logic cur,
                                       input logic [CNT_W-1:0] b,
                                       input logic [IDX_W-1:0] rise,
                                       input logic [IDX_W-1:0] fall,
                                       input logic [CNT_W-1:0] n);
    logic nxt;
    nxt = cur;
    if (b < n) begin
      if ({1'b0, fall} == b)      nxt = 1'b0;
      else if ({1'b0, rise} == b) nxt = 1'b1;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/synl_regs.sv
module synl_regs
  import synl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       idle,
  input  logic       lock_fail,
  output logic [7:0] rdata,
  output synl_cfg_t  cfg,
  output logic       start,
  output logic [CNT_W-1:0] start_pulses
);
  localparam int NBYTE = WORD_W / 8;

  logic [7:0] byte_q [NBYTE];
  logic [7:0] c0_q, c1_q, c2_q;
  logic       wr_ok;

  assign wr_ok = wr_en && idle;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        byte_q[g] <= '0;
      else if (wr_ok && addr == 3'(g))   byte_q[g] <= wdata;
    end
    assign cfg.word[8*g +: 8] = byte_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
      c2_q <= 8'h20;
    end else if (wr_ok) begin
      if (addr == A_CFG0) c0_q <= wdata;
      if (addr == A_CFG1) c1_q <= {2'b00, wdata[5:0]};
      if (addr == A_CFG2) c2_q <= {2'b00, wdata[5:0]};
    end
  end

  assign start        = wr_ok && (addr == A_CFG2);
  assign start_pulses = pulses_of(wdata[IDX_W-1:0]);

  assign cfg.sel       = c0_q[7:5];
  assign cfg.fall_idx  = c0_q[4:0];
  assign cfg.msb_first = c1_q[5];
  assign cfg.rise_idx  = c1_q[4:0];
  assign cfg.pol       = c2_q[5];
  assign cfg.pcode     = c2_q[4:0];

  always_comb begin
    unique case (addr)
      A_CFG0:  rdata = c0_q;
      A_CFG1:  rdata = c1_q;
      A_CFG2:  rdata = c2_q;
      A_STAT:  rdata = {6'b0, lock_fail, idle};
      default: rdata = byte_q[addr[1:0]];
    endcase
  end
endmodule

// File: rtl/synl_shifter.sv
module synl_shifter
  import synl_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  synl_cfg_t        cfg,
  input  logic             start,
  input  logic [CNT_W-1:0] start_pulses,
  output logic             busy,
  output logic             bit_end,
  output logic             sclk,
  output logic             sdata,
  output logic [NSTB-1:0]  strobe
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] bit_q;
  logic             lvl_q;
  logic [CNT_W-1:0] n_pulses;
  logic             last_bit;
  logic             active_half;

  assign n_pulses    = pulses_of(cfg.pcode);
  assign bit_end     = busy && (ph_q == PH_W'(CLK_DIV - 1));
  assign last_bit    = ({1'b0, bit_q} == n_pulses - CNT_W'(1));
  assign active_half = busy && (ph_q >= PH_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      lvl_q <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      ph_q  <= '0;
      bit_q <= '0;
      lvl_q <= strobe_step(1'b0, '0, cfg.rise_idx, cfg.fall_idx, start_pulses);
    end else if (busy) begin
      if (!bit_end) begin
        ph_q <= ph_q + PH_W'(1);
      end else if (last_bit) begin
        busy  <= 1'b0;
        ph_q  <= '0;
        bit_q <= '0;
        lvl_q <= 1'b0;
      end else begin
        ph_q  <= '0;
        bit_q <= bit_q + IDX_W'(1);
        lvl_q <= strobe_step(lvl_q, {1'b0, bit_q} + CNT_W'(1),
                             cfg.rise_idx, cfg.fall_idx, n_pulses);
      end
    end
  end

  assign sclk   = active_half ^ ~cfg.pol;
  assign sdata  = busy && bit_at(cfg.word, cfg.msb_first, bit_q);
  assign strobe = {NSTB{lvl_q}} & cfg.sel;
endmodule

// File: rtl/synl_txgate.sv
module synl_txgate #(
  parameter int IQ_W = 12
) (
  input  logic            lock_fail,
  input  logic            pa_en_in,
  input  logic [IQ_W-1:0] txi_in,
  input  logic [IQ_W-1:0] txq_in,
  output logic            pa_en,
  output logic [IQ_W-1:0] txi,
  output logic [IQ_W-1:0] txq
);
  assign pa_en = pa_en_in && !lock_fail;
  assign txi   = lock_fail ? '0 : txi_in;
  assign txq   = lock_fail ? '0 : txq_in;
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synl_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int IQ_W    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            ready,
  output logic            sclk,
  output logic            sdata,
  output logic [2:0]      strobe,
  input  logic            out_of_lock,
  input  logic            pa_en_in,
  input  logic [IQ_W-1:0] txi_in,
  input  logic [IQ_W-1:0] txq_in,
  output logic            pa_en,
  output logic [IQ_W-1:0] txi,
  output logic [IQ_W-1:0] txq
);
  synl_cfg_t        cfg;
  logic             start_ev;
  logic             bit_end_ev;
  logic             busy;
  logic [CNT_W-1:0] start_pulses;
  logic [WORD_W-1:0] cfg_word;
  logic [NSTB-1:0]  cfg_sel;
  logic             cfg_pol;

  assign ready    = !busy;
  assign cfg_word = cfg.word;
  assign cfg_sel  = cfg.sel;
  assign cfg_pol  = cfg.pol;

  synl_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .idle         (ready),
    .lock_fail    (out_of_lock),
    .rdata        (rdata),
    .cfg          (cfg),
    .start        (start_ev),
    .start_pulses (start_pulses)
  );

  synl_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg          (cfg),
    .start        (start_ev),
    .start_pulses (start_pulses),
    .busy         (busy),
    .bit_end      (bit_end_ev),
    .sclk         (sclk),
    .sdata        (sdata),
    .strobe       (strobe)
  );

  synl_txgate #(.IQ_W(IQ_W)) u_gate (
    .lock_fail (out_of_lock),
    .pa_en_in  (pa_en_in),
    .txi_in    (txi_in),
    .txq_in    (txq_in),
    .pa_en     (pa_en),
    .txi       (txi),
    .txq       (txq)
  );
endmodule

// File: rtl/synth_loader_chk.sv
module synth_loader_chk #(
  parameter int IQ_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_ev,
  input logic            wr_en,
  input logic            ready,
  input logic            sclk,
  input logic            sdata,
  input logic [2:0]      strobe,
  input logic [2:0]      cfg_sel,
  input logic            cfg_pol,
  input logic [31:0]     cfg_word,
  input logic            out_of_lock,
  input logic            pa_en,
  input logic [IQ_W-1:0] txi,
  input logic [IQ_W-1:0] txq
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !ready); // R3

  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sclk == !cfg_pol)); // R5

  AST_EDGE_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && $changed(sclk) && sclk == cfg_pol) |-> $stable(sdata)); // R7

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (strobe == 3'b000)); // R8

  AST_SEL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe & ~cfg_sel) == 3'b000); // R10

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && wr_en) |=> $stable(cfg_word)); // R11

  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_lock |-> (!pa_en && txi == '0 && txq == '0)); // R12
endmodule

bind synth_loader synth_loader_chk #(.IQ_W(IQ_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_ev    (start_ev),
  .wr_en       (wr_en),
  .ready       (ready),
  .sclk        (sclk),
  .sdata       (sdata),
  .strobe      (strobe),
  .cfg_sel     (cfg_sel),
  .cfg_pol     (cfg_pol),
  .cfg_word    (cfg_word),
  .out_of_lock (out_of_lock),
  .pa_en       (pa_en),
  .txi         (txi),
  .txq         (txq)
);

// File: tb/test_synth_loader.sv
`timescale 1ns/1ps
module test_synth_loader;
  localparam int DIV  = 4;
  localparam int IQW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ready, sclk, sdata;
  logic [2:0] strobe;
  logic out_of_lock = 1'b0;
  logic pa_en_in = 1'b0;
  logic [IQW-1:0] txi_in = '0, txq_in = '0;
  logic pa_en;
  logic [IQW-1:0] txi, txq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  synth_loader #(.CLK_DIV(DIV), .IQ_W(IQW)) i_synth_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .sclk(sclk), .sdata(sdata), .strobe(strobe),
    .out_of_lock(out_of_lock), .pa_en_in(pa_en_in), .txi_in(txi_in),
    .txq_in(txq_in), .pa_en(pa_en), .txi(txi), .txq(txq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  // strobe high at bit b: rise valid and reached, no valid fall in [rise, b]
  function automatic bit exp_strobe(int b, int rise, int fall, int n);
    return (rise < n) && (rise <= b) && !((fall < n) && (fall >= rise) && (fall <= b));
  endfunction

  // load registers, start, sample every cycle of the transfer
  task automatic run_xfer(input logic [31:0] w, input logic [2:0] sel,
                          input int rise, input int fall, input bit msb,
                          input bit pol, input int code, input int inj_j,
                          input string tag);
    int n;
    n = (code == 0) ? 32 : code;
    for (int i = 0; i < 4; i++) wr(3'(i), w[8*i +: 8]);
    wr(3'd4, {sel, 5'(fall)});
    wr(3'd5, {2'b00, msb, 5'(rise)});
    wr(3'd6, {2'b00, pol, 5'(code)});
    for (int j = 0; j < n * DIV; j++) begin
      int b;
      bit eb, ec, es;
      b  = j / DIV;
      eb = msb ? w[31 - b] : w[b];
      ec = ((j % DIV) >= DIV / 2) ? pol : !pol;
      es = exp_strobe(b, rise, fall, n);
      check(ready == 1'b0, {tag, " R3 busy"}, ready, 0);
      check(sdata == eb, {tag, " R6 data bit"}, sdata, eb);
      check(sclk == ec, {tag, " R5 clock level"}, sclk, ec);
      check(strobe == ({3{es}} & sel), {tag, " R8 R9 R10 strobe"}, strobe, {3{es}} & sel);
      if (j == inj_j) begin
        wr_en = 1'b1; addr = 3'd0; wdata = ~w[7:0];
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    check(ready == 1'b1, {tag, " R3 R4 ready after N*DIV"}, ready, 1);
    check(strobe == 3'b000, {tag, " R8 strobe low at end"}, strobe, 0);
    check(sclk == !pol, {tag, " R5 idle clock"}, sclk, !pol);
    check(sdata == 1'b0, {tag, " R6 idle data"}, sdata, 0);
  endtask

  task automatic t_reset;
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(sdata == 1'b0, "R1 sdata", sdata, 0);
    check(strobe == 3'b000, "R1 strobe", strobe, 0);
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reg zero");
    rd_chk(3'd6, 8'h20, "R1 cfg2 reset");
    rd_chk(3'd7, 8'h01, "R1 R2 status idle");
  endtask

  task automatic t_regs;
    wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33); wr(3'd3, 8'h44);
    wr(3'd4, 8'hE7); wr(3'd5, 8'hFF);
    rd_chk(3'd0, 8'h11, "R2 byte0");
    rd_chk(3'd3, 8'h44, "R2 byte3");
    rd_chk(3'd4, 8'hE7, "R2 cfg0");
    rd_chk(3'd5, 8'h3F, "R2 cfg1 reserved zero");
  endtask

  task automatic t_lsb32;
    run_xfer(32'hA5C3_1E72, 3'b001, 0, 31, 1'b0, 1'b1, 0, -1, "lsb32 R4");
  endtask

  task automatic t_msb8;
    run_xfer(32'h81F0_0F3C, 3'b101, 2, 6, 1'b1, 1'b0, 8, -1, "msb8 R6");
    rd_chk(3'd6, 8'h08, "R2 cfg2 readback");
  endtask

  task automatic t_rise_out;
    run_xfer(32'h0F0F_F0F0, 3'b111, 10, 3, 1'b0, 1'b1, 8, -1, "rise_out R9");
  endtask

  task automatic t_fall_out_busy_wr;
    run_xfer(32'h5A5A_C3C3, 3'b010, 1, 20, 1'b1, 1'b1, 5, 6, "fall_out R9 R11");
    rd_chk(3'd0, 8'hC3, "R11 busy write ignored");
  endtask

  task automatic t_equal;
    run_xfer(32'hFFFF_0001, 3'b110, 4, 4, 1'b0, 1'b1, 6, -1, "equal R8");
  endtask

  task automatic t_busy_status;
    wr(3'd6, 8'h23);
    rd_chk(3'd7, 8'h00, "R2 status busy");
    wr(3'd6, 8'h01);
    repeat (3 * DIV) @(negedge clk);
    check(ready == 1'b1, "R11 restart write ignored", ready, 1);
    rd_chk(3'd6, 8'h23, "R11 cfg2 unchanged");
  endtask

  task automatic t_lock;
    pa_en_in = 1'b1; txi_in = 12'hABC; txq_in = 12'h123; out_of_lock = 1'b0;
    #1;
    check(pa_en == 1'b1 && txi == 12'hABC && txq == 12'h123, "R12 pass", {pa_en, txi, txq}, {1'b1, 12'hABC, 12'h123});
    out_of_lock = 1'b1;
    #1;
    check(pa_en == 1'b0 && txi == '0 && txq == '0, "R12 gated", {pa_en, txi, txq}, 0);
    rd_chk(3'd7, 8'h03, "R2 R12 lock status");
    out_of_lock = 1'b0;
    #1;
    check(pa_en == 1'b1, "R12 release", pa_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_lsb32();
    t_msb8();
    t_rise_out();
    t_fall_out_busy_wr();
    t_equal();
    t_busy_status();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule